// File: doc/BRIEF.md
# Pulse-Counted Boot Interface Selector

This block picks the serial interface for a flash-programming session. Once reset is released, the block counts rising edges on a mode pin. The pin is asynchronous and goes through a two-flop synchroniser inside the block. A window-close strobe tells the block to decode the count a single time. The count then selects one of three interfaces: a UART, a clocked serial slave, or a clocked serial slave with handshake. Any count outside these legal values is refused and raises an error.

After the decode, the result stays latched until the next reset. A done flag marks the point from which the outputs are valid. The block also reports the bit order and the slave role for the chosen interface to the datapath. The UART runs LSB first at a post-reset rate of 9600 bps. Both clocked modes are slaves and run MSB first. The shifters themselves sit outside this block.

Top module: `boot_if_select`

## Requirements
- R1: Edges on `mode_pin` while `rst_n` is low are ignored. Counting starts from zero at reset release, and `mode_pin` must be low at that moment.
- R2: A count of 0 gives `if_sel` = 3'b001 (bit 0 = UART), with `lsb_first` = 1 and `slave_role` = 0.
- R3: A count of exactly `SER_PULSES` (default 8) gives `if_sel` = 3'b010 (bit 1 = clocked serial), with `lsb_first` = 0 and `slave_role` = 1.
- R4: A count of exactly `SER_HS_PULSES` (default 11) gives `if_sel` = 3'b100 (bit 2 = clocked serial with handshake), with `lsb_first` = 0 and `slave_role` = 1.
- R5: Any other count gives `sel_err` = 1, with `if_sel`, `lsb_first` and `slave_role` all 0.
- R6: The edge count saturates at 2**`CNT_W`-1 (15 by default). Any longer train is an error and never wraps onto a legal count.
- R7: `sel_done` is low after reset. It rises one cycle after the first cycle in which `win_close` is high, and stays high until reset. While `sel_done` is low, all other outputs are 0.
- R8: Once `sel_done` is high, further pin edges and further strobes leave every output unchanged.
- R9: Only rising edges count, after two synchroniser flops. A pulse that is one clock high and one clock low counts once. An edge is included if it occurs at least 3 cycles before the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_pin | input | 1 | Asynchronous mode pin carrying the pulse train |
| win_close | input | 1 | Strobe that ends counting and triggers the decode |
| if_sel | output | 3 | One-hot interface select: bit 0 UART, bit 1 clocked serial, bit 2 clocked serial with handshake |
| sel_err | output | 1 | Prohibited count seen |
| sel_done | output | 1 | Decode complete; the other outputs are valid |
| lsb_first | output | 1 | Selected interface transfers LSB first |
| slave_role | output | 1 | Selected interface runs as slave |

## Verification
The bench sends counts next to each legal value (7, 9, 10, 12) and also 1. A decoder that matched only some of the bits would accept one of these. It sends 16 and 24 pulses: a counter that wraps instead of saturating would read 24 as 8 and pick the clocked serial mode. Pulses sent during reset, and pulses and strobes sent after done, must leave the result unchanged. A synchroniser that missed resetting, or a latch that did not freeze, would show a changed mode. Single-cycle pulses check that the edge detector neither merges nor splits edges.

// File: rtl/boot_if_select.sv
module boot_if_select #(
  parameter int CNT_W         = 4,
  parameter int SER_PULSES    = 8,
  parameter int SER_HS_PULSES = 11
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_pin,
  input  logic       win_close,
  output logic [2:0] if_sel,
  output logic       sel_err,
  output logic       sel_done,
  output logic       lsb_first,
  output logic       slave_role
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_SER = CNT_W'(SER_PULSES);
  localparam logic [CNT_W-1:0] CNT_HS  = CNT_W'(SER_HS_PULSES);

  logic [2:0]       pin_sh;
  logic [CNT_W-1:0] cnt;
  logic [2:0]       dec_sel;
  logic             rise;

  assign rise = pin_sh[1] & ~pin_sh[2];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pin_sh <= '0;
    else        pin_sh <= {pin_sh[1:0], mode_pin};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cnt <= '0;
    else if (!sel_done && rise && cnt != CNT_MAX) cnt <= cnt + 1'b1;

  always_comb begin
    dec_sel = 3'b000;
    if (cnt == '0)          dec_sel = 3'b001;
    else if (cnt == CNT_SER) dec_sel = 3'b010;
    else if (cnt == CNT_HS)  dec_sel = 3'b100;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sel_done <= 1'b0;
      if_sel   <= '0;
      sel_err  <= 1'b0;
    end else if (win_close && !sel_done) begin
      sel_done <= 1'b1;
      if_sel   <= dec_sel;
      sel_err  <= (dec_sel == 3'b000);
    end

  assign lsb_first  = if_sel[0];
  assign slave_role = if_sel[1] | if_sel[2];

  p_sat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt == CNT_MAX |=> cnt == CNT_MAX);
  p_done_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sel_done |=> sel_done);
  p_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_done |-> (if_sel == 3'b000 && !sel_err));
  p_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sel_done |-> ($onehot0(if_sel) && (sel_err == (if_sel == 3'b000))));
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_done && $past(sel_done)) |-> ($stable(if_sel) && $stable(sel_err)));
  p_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (win_close && !sel_done) |=> sel_done);
endmodule

// File: tb/boot_if_select_tb.sv
`timescale 1ns/1ps
module boot_if_select_tb;
  logic clk = 0, rst_n = 0, mode_pin = 0, win_close = 0;
  logic [2:0] if_sel;
  logic sel_err, sel_done, lsb_first, slave_role;
  int checks = 0, fails = 0;
  int pulses_sent = 0;
  bit exp_done = 0, exp_err = 0;
  logic [2:0] exp_sel = 0;
  string mode_tag = "R7";

  always #2.5 clk = ~clk;

  boot_if_select u_dut (.clk(clk), .rst_n(rst_n), .mode_pin(mode_pin), .win_close(win_close),
    .if_sel(if_sel), .sel_err(sel_err), .sel_done(sel_done), .lsb_first(lsb_first),
    .slave_role(slave_role));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference
  always @(posedge clk or negedge rst_n)
    if (!rst_n) begin exp_done <= 0; exp_sel <= 0; exp_err <= 0; end
    else if (win_close && !exp_done) begin
      int n;
      n = (pulses_sent > 15) ? 15 : pulses_sent;
      exp_done <= 1;
      if (n == 0)       begin exp_sel <= 3'b001; exp_err <= 0; end
      else if (n == 8)  begin exp_sel <= 3'b010; exp_err <= 0; end
      else if (n == 11) begin exp_sel <= 3'b100; exp_err <= 0; end
      else              begin exp_sel <= 3'b000; exp_err <= 1; end
    end

  always @(negedge clk) begin
    chk("R7 done", sel_done, exp_done);
    chk({mode_tag, " sel"}, if_sel, exp_sel);
    chk({mode_tag, " err"}, sel_err, exp_err);
    chk({mode_tag, " lsb_first"}, lsb_first, exp_sel[0]);
    chk({mode_tag, " slave_role"}, slave_role, exp_sel[1] | exp_sel[2]);
  end

  task automatic pulse(int hi, int lo);
    @(negedge clk); mode_pin = 1;
    if (rst_n && !exp_done) pulses_sent++;
    repeat (hi) @(negedge clk);
    mode_pin = 0;
    repeat (lo - 1) @(negedge clk);
  endtask

  task automatic run(string tag, int n, int hi, int lo, int rst_pulses);
    @(negedge clk); #1 rst_n = 0;
    mode_tag = "R1";
    pulses_sent = 0;
    for (int i = 0; i < rst_pulses; i++) pulse(1, 2);
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    mode_tag = tag;
    for (int i = 0; i < n; i++) pulse(hi, lo);
    repeat (4) @(negedge clk);
    win_close = 1;
    @(negedge clk); win_close = 0;
    repeat (2) @(negedge clk);
    mode_tag = "R8";
    for (int i = 0; i < 8; i++) pulse(1, 1);
    repeat (4) @(negedge clk);
    win_close = 1;
    @(negedge clk); win_close = 0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #1000000;
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    run("R2", 0, 2, 2, 0);
    run("R1", 0, 2, 2, 5);
    run("R3", 8, 2, 2, 0);
    run("R4", 11, 2, 2, 3);
    run("R5", 7, 2, 2, 0);
    run("R5", 9, 2, 2, 0);
    run("R5", 10, 2, 2, 0);
    run("R5", 12, 2, 2, 0);
    run("R5", 1, 3, 2, 0);
    run("R6", 15, 2, 2, 0);
    run("R6", 16, 2, 2, 0);
    run("R6", 24, 2, 2, 0);
    run("R9", 8, 1, 1, 0);
    run("R9", 11, 3, 1, 2);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule